// File: doc/BRIEF.md
# Dual-Bank Flash Read-While-Write Arbiter

This block sits between a single bus master and two flash banks. One high address bit steers each access: one value selects the code bank and the other selects the data bank. Reads are accepted at any size and alignment. A write is forwarded to a bank only when it is a full, aligned word, and the forwarded write starts a program operation in that bank. Any other write gets an error response and goes no further.

A read can reach a bank that is still programming. A two-bit configuration field then decides what happens. The read can wait until the operation ends. It can instead cut the operation short, so that the word in the bank is left unchanged. Either action can also set a sticky interrupt flag, which software clears by writing a one to it. The bank arrays are represented by a busy/ready stub that holds one word per bank. The stub stays busy for a fixed number of cycles after a program starts, and for a shorter fixed tail after an abort.

Top module: `rww_arbiter`

## Requirements
- R1: Address bit 23 selects the bank, with 0 for the code bank and 1 for the data bank. A read of a bank returns the last word completely programmed into that bank, whatever the other address bits are.
- R2: A write is rejected when its size code is not 2'b10 (00 byte, 01 half, 10 word, 11 reserved) or when address bits [1:0] are nonzero. The rejection is a two-cycle error response: the first cycle has error high and ready low, the second has error and ready both high. The bank is not started and its word is unchanged.
- R3: An accepted word write to an idle bank completes with ready in the second cycle after the request is taken and with no error. The bank then reports busy for PROG_CYCLES cycles, and its word takes the written value at the end.
- R4: A read of a bank that is not busy returns ready in the second cycle after the request is taken, even while the other bank is busy.
- R5: With cfg_rww = 00 or 01, a read of a busy bank waits until the bank is idle and returns the newly programmed word.
- R6: A stalled read sets the stall flag only when cfg_rww = 01. With 00 the flag stays clear.
- R7: With cfg_rww = 10 or 11, a read of a busy bank aborts the operation. The bank turns idle within ABORT_CYCLES cycles, the read is issued only once the bank reports ready, it returns the old word, and the aborted word is discarded.
- R8: An aborted operation sets the abort flag only when cfg_rww = 11. With 10 the flag stays clear.
- R9: Both flags are sticky and are driven out as interrupt lines. A one on flag_clr bit 0 clears the stall flag and a one on bit 1 clears the abort flag. Neither clear bit touches the other flag.
- R10: After reset, ready, error, both interrupts and both busy indications are low, and both bank words read as zero.
- R11: A word write to a busy bank is held until the bank is idle, and is then forwarded and programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_rww | input | 2 | Read-while-write policy: bit 1 aborts, bit 0 raises the interrupt |
| bus_valid | input | 1 | Request present, held until ready |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | ADDR_W (24) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data, held with the request |
| bus_ready | output | 1 | Response cycle |
| bus_err | output | 1 | Error response |
| bus_rdata | output | DATA_W (32) | Read data, valid with ready |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 stall, bit 1 abort |
| irq_stall | output | 1 | Sticky stall-notification flag |
| irq_abort | output | 1 | Sticky abort-notification flag |
| bank_busy | output | 2 | Bank operation in progress, bit 0 code bank |

## Verification
The assertions assume that a master keeps bus_valid and the request fields steady until it sees ready, and drops the request in the cycle after ready. They also assume that cfg_rww does not change while a request is being served. The bench drives every request through one task that follows this handshake, and it changes the policy only once both banks are idle and no request is pending. Abort and stall cases are started right after a program begins, so the read always meets the bank well before the program's normal end.

// File: rtl/rww_pkg.sv
package rww_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ERR1,
      ST_ERR2,
      ST_WR,
      ST_RD,
      ST_WAIT,
      ST_RESP
   } ctrl_st_e;

   // policy field bit meanings
   localparam int POL_ABORT_BIT = 1;
   localparam int POL_IRQ_BIT   = 0;

   // flag vector positions
   localparam int FLG_STALL = 0;
   localparam int FLG_ABORT = 1;
   localparam int FLG_N     = 2;

   localparam int BANK_N    = 2;
endpackage

// File: rtl/rww_req_decode.sv
module rww_req_decode #(
   parameter int ADDR_W   = 24,
   parameter int BANK_BIT = 23,
   parameter int DATA_W   = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              bank_sel,
   output logic              write_legal
);
   localparam int BYTES     = DATA_W / 8;
   localparam int ALIGN_LSB = $clog2(BYTES);
   localparam logic [1:0] WORD_CODE = 2'(ALIGN_LSB);

   assign bank_sel = addr[BANK_BIT];

   generate
      if (ALIGN_LSB == 0) begin : g_byte_word
         assign write_legal = (size == WORD_CODE);
      end else begin : g_multi_byte
         assign write_legal = (size == WORD_CODE) && (addr[ALIGN_LSB-1:0] == '0);
      end
   endgenerate
endmodule

// File: rtl/rww_bank_stub.sv
module rww_bank_stub #(
   parameter int DATA_W       = 32,
   parameter int PROG_CYCLES  = 20,
   parameter int ABORT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic [DATA_W-1:0] word
);
   localparam int CNT_W = $clog2(PROG_CYCLES + 1);
   localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES);
   localparam logic [CNT_W-1:0] ABORT_LD = CNT_W'(ABORT_CYCLES);

   logic [CNT_W-1:0]  cnt_q;
   logic              aborting_q;
   logic [DATA_W-1:0] pend_q;
   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         aborting_q <= 1'b0;
         pend_q     <= '0;
         word_q     <= '0;
      end else if (start) begin
         cnt_q      <= PROG_LD;
         pend_q     <= wdata;
         aborting_q <= 1'b0;
      end else if (cnt_q != '0) begin
         if (abort && !aborting_q && (cnt_q > ABORT_LD)) begin
            cnt_q      <= ABORT_LD;
            aborting_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               if (!aborting_q) word_q <= pend_q;
               aborting_q <= 1'b0;
            end
         end
      end
   end

   assign busy = (cnt_q != '0);
   assign word = word_q;

   assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   assert_abort_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> busy);
   assert_abort_keeps_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aborting_q && cnt_q == CNT_W'(1)) |=> $stable(word_q));
endmodule

// File: rtl/rww_flags.sv
module rww_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (clr[i]) f_q <= 1'b0;
         end
         assign flag[i] = f_q;

         assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr[i]) |=> flag[i]);
         assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(set[i]));
      end
   endgenerate
endmodule

// File: rtl/rww_ctrl.sv
module rww_ctrl
   import rww_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    policy,
   input  logic                          valid,
   input  logic                          write,
   input  logic                          bank_sel,
   input  logic                          write_legal,
   input  logic [BANK_N-1:0]             busy,
   input  logic [BANK_N-1:0][DATA_W-1:0] bank_word,
   output logic                          bus_ready,
   output logic                          bus_err,
   output logic [DATA_W-1:0]             rdata,
   output logic [BANK_N-1:0]             start,
   output logic [BANK_N-1:0]             abort,
   output logic                          stall_evt,
   output logic                          abort_evt
);
   ctrl_st_e          st_q, st_d;
   logic              bank_q, write_q;
   logic [DATA_W-1:0] rdata_q;
   logic              tgt_busy;

   assign tgt_busy = busy[bank_q];

   always_comb begin
      st_d      = st_q;
      start     = '0;
      abort     = '0;
      stall_evt = 1'b0;
      abort_evt = 1'b0;
      case (st_q)
         ST_IDLE: if (valid) st_d = write ? (write_legal ? ST_WR : ST_ERR1) : ST_RD;
         ST_ERR1: st_d = ST_ERR2;
         ST_ERR2: st_d = ST_IDLE;
         ST_WR: begin
            if (!tgt_busy) begin
               start[bank_q] = 1'b1;
               st_d          = ST_RESP;
            end
         end
         ST_RD: begin
            if (!tgt_busy) begin
               st_d = ST_RESP;
            end else begin
               st_d = ST_WAIT;
               if (policy[POL_ABORT_BIT]) begin
                  abort[bank_q] = 1'b1;
                  abort_evt     = policy[POL_IRQ_BIT];
               end else begin
                  stall_evt = policy[POL_IRQ_BIT];
               end
            end
         end
         ST_WAIT: if (!tgt_busy) st_d = ST_RESP;
         ST_RESP: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bank_q  <= 1'b0;
         write_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && valid) begin
            bank_q  <= bank_sel;
            write_q <= write;
         end
         if ((st_q == ST_RD || st_q == ST_WAIT) && !tgt_busy)
            rdata_q <= bank_word[bank_q];
      end
   end

   assign bus_ready = (st_q == ST_RESP) || (st_q == ST_ERR2);
   assign bus_err   = (st_q == ST_ERR1) || (st_q == ST_ERR2);
   assign rdata     = rdata_q;

   assert_err_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !bus_ready) |=> (bus_err && bus_ready));
   assert_read_idle_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && !bus_err && !write_q) |-> !busy[bank_q]);
   assert_abort_policy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|abort) |-> policy[POL_ABORT_BIT]);
   assert_stall_policy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_evt |-> (policy == 2'b01));
   assert_start_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start) && !(|(start & busy)));
endmodule

// File: rtl/rww_arbiter.sv
module rww_arbiter
   import rww_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int BANK_BIT     = 23,
   parameter int DATA_W       = 32,
   parameter int PROG_CYCLES  = 20,
   parameter int ABORT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_rww,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ready,
   output logic              bus_err,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [1:0]        flag_clr,
   output logic              irq_stall,
   output logic              irq_abort,
   output logic [1:0]        bank_busy
);
   generate
      if (BANK_BIT >= ADDR_W) begin : g_bad_bank_bit
         $error("BANK_BIT must lie inside the address");
      end
      if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 64) begin : g_bad_width
         $error("DATA_W must be 8..64 and a whole number of bytes");
      end
      if (ABORT_CYCLES < 1 || PROG_CYCLES <= ABORT_CYCLES) begin : g_bad_timing
         $error("PROG_CYCLES must exceed ABORT_CYCLES, which must be nonzero");
      end
   endgenerate

   logic                          bank_sel, write_legal;
   logic [BANK_N-1:0]             start, abort, busy;
   logic [BANK_N-1:0][DATA_W-1:0] bank_word;
   logic                          stall_evt, abort_evt;
   logic [FLG_N-1:0]              flag_set, flag_q;

   rww_req_decode #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .DATA_W(DATA_W)) u_dec (
      .addr(bus_addr), .size(bus_size), .bank_sel(bank_sel), .write_legal(write_legal));

   rww_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .policy(cfg_rww), .valid(bus_valid), .write(bus_write),
      .bank_sel(bank_sel), .write_legal(write_legal), .busy(busy), .bank_word(bank_word),
      .bus_ready(bus_ready), .bus_err(bus_err), .rdata(bus_rdata), .start(start),
      .abort(abort), .stall_evt(stall_evt), .abort_evt(abort_evt));

   generate
      for (genvar b = 0; b < BANK_N; b++) begin : g_bank
         rww_bank_stub #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES),
                         .ABORT_CYCLES(ABORT_CYCLES)) u_bank (
            .clk(clk), .rst_n(rst_n), .start(start[b]), .abort(abort[b]),
            .wdata(bus_wdata), .busy(busy[b]), .word(bank_word[b]));
      end
   endgenerate

   assign flag_set[FLG_STALL] = stall_evt;
   assign flag_set[FLG_ABORT] = abort_evt;

   rww_flags #(.N(FLG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flag(flag_q));

   assign irq_stall = flag_q[FLG_STALL];
   assign irq_abort = flag_q[FLG_ABORT];
   assign bank_busy = busy;

   assert_abort_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_abort) |-> ($past(cfg_rww) == 2'b11));
endmodule

// File: tb/tb_rww_arbiter.sv
module tb_rww_arbiter;
   localparam int PROG  = 20;
   localparam int ABRT  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_rww = 2'b00;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [1:0]  bus_size = 2'b10;
   logic [23:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready, bus_err, irq_stall, irq_abort;
   logic [31:0] bus_rdata;
   logic [1:0]  flag_clr = 2'b00;
   logic [1:0]  bank_busy;

   int checks = 0, errors = 0, cyc = 0;
   int lat, errc;
   logic [31:0] rd;

   always #10 clk = ~clk;

   rww_arbiter #(.PROG_CYCLES(PROG), .ABORT_CYCLES(ABRT)) dut (
      .clk, .rst_n, .cfg_rww, .bus_valid, .bus_write, .bus_size, .bus_addr, .bus_wdata,
      .bus_ready, .bus_err, .bus_rdata, .flag_clr, .irq_stall, .irq_abort, .bank_busy);

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic txn(input logic wr, input logic [1:0] sz, input logic [23:0] a,
                      input logic [31:0] d, output int l, output int ec, output logic [31:0] r);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
      l = 0; ec = 0;
      do begin
         @(negedge clk);
         l++;
         if (bus_err) ec++;
      end while (!bus_ready && l < 2000);
      r = bus_rdata;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic wait_idle();
      while (bank_busy != 2'b00) @(negedge clk);
   endtask

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [23:0] addr;
      logic [31:0] data;
      logic        exp_err;
      logic [31:0] exp_rd;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'b10, 24'h000010, 32'hA5A50001, 1'b0, 32'h0},
      '{1'b0, 2'b10, 24'h000020, 32'h0,        1'b0, 32'hA5A50001},
      '{1'b1, 2'b10, 24'h800004, 32'h5A5A0002, 1'b0, 32'h0},
      '{1'b0, 2'b10, 24'h800000, 32'h0,        1'b0, 32'h5A5A0002},
      '{1'b0, 2'b01, 24'h7FFFFE, 32'h0,        1'b0, 32'hA5A50001},
      '{1'b1, 2'b10, 24'h000002, 32'hDEAD0003, 1'b1, 32'h0},
      '{1'b1, 2'b01, 24'h800000, 32'hDEAD0004, 1'b1, 32'h0},
      '{1'b1, 2'b11, 24'h000008, 32'hDEAD0005, 1'b1, 32'h0},
      '{1'b0, 2'b10, 24'h000000, 32'h0,        1'b0, 32'hA5A50001},
      '{1'b1, 2'b10, 24'hFFFFFC, 32'h12345678, 1'b0, 32'h0},
      '{1'b0, 2'b00, 24'h800003, 32'h0,        1'b0, 32'h12345678}
   };

   initial begin
      // R10: reset state
      #25;
      @(negedge clk);
      chk(bus_ready == 1'b0 && bus_err == 1'b0, "R10 ready/err in reset", {30'd0, bus_ready, bus_err}, 32'h0);
      chk(irq_stall == 1'b0 && irq_abort == 1'b0, "R10 irqs in reset", {30'd0, irq_stall, irq_abort}, 32'h0);
      chk(bank_busy == 2'b00, "R10 busy in reset", {30'd0, bank_busy}, 32'h0);
      rst_n = 1'b1;
      txn(1'b0, 2'b10, 24'h000000, 0, lat, errc, rd);
      chk(rd == 32'h0, "R10 code bank word after reset", rd, 32'h0);
      txn(1'b0, 2'b10, 24'h800000, 0, lat, errc, rd);
      chk(rd == 32'h0, "R10 data bank word after reset", rd, 32'h0);

      // Table walk: R1 steering, R2 rejects, R3 write timing, R4 read timing
      for (int i = 0; i < NV; i++) begin
         wait_idle();
         txn(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].data, lat, errc, rd);
         if (VECS[i].exp_err) begin
            chk(errc == 2 && lat == 2, "R2 two-cycle error", errc, 2);
            @(negedge clk);
            chk(bank_busy == 2'b00, "R2 rejected write not forwarded", {30'd0, bank_busy}, 32'h0);
         end else if (VECS[i].wr) begin
            chk(errc == 0 && lat == 2, "R3 write response", lat, 2);
            chk(bank_busy[VECS[i].addr[23]] == 1'b1, "R3 bank busy after write",
                {31'd0, bank_busy[VECS[i].addr[23]]}, 32'h1);
         end else begin
            chk(errc == 0 && lat == 2, "R4 read latency", lat, 2);
            chk(rd == VECS[i].exp_rd, "R1 read data by bank", rd, VECS[i].exp_rd);
         end
      end

      // R3: busy duration close to PROG cycles
      wait_idle();
      txn(1'b1, 2'b10, 24'h000040, 32'h00C0FFEE, lat, errc, rd);
      begin
         int n = 0;
         while (bank_busy[0]) begin @(negedge clk); n++; end
         chk(n >= PROG - 2 && n <= PROG, "R3 program duration", n, PROG);
      end

      // R4: read other bank while code bank busy
      txn(1'b1, 2'b10, 24'h000044, 32'h11110001, lat, errc, rd);
      txn(1'b0, 2'b10, 24'h800000, 0, lat, errc, rd);
      chk(lat == 2 && rd == 32'h12345678, "R4 idle bank read during busy", lat, 2);
      chk(bank_busy[0] == 1'b1, "R4 code bank still busy", {31'd0, bank_busy[0]}, 32'h1);

      // R11: write to busy bank is held
      txn(1'b1, 2'b10, 24'h000048, 32'h22220002, lat, errc, rd);
      chk(lat > 2 && errc == 0, "R11 write waits for busy bank", lat, 3);
      wait_idle();
      txn(1'b0, 2'b10, 24'h000000, 0, lat, errc, rd);
      chk(rd == 32'h22220002, "R11 held write programmed", rd, 32'h22220002);

      // R5/R6: stall without interrupt
      cfg_rww = 2'b00;
      txn(1'b1, 2'b10, 24'h000000, 32'h33330003, lat, errc, rd);
      txn(1'b0, 2'b10, 24'h000000, 0, lat, errc, rd);
      chk(lat > ABRT + 3, "R5 read stalls", lat, ABRT + 4);
      chk(rd == 32'h33330003, "R5 stalled read returns new word", rd, 32'h33330003);
      chk(irq_stall == 1'b0, "R6 no stall irq with policy 00", {31'd0, irq_stall}, 32'h0);

      // R5/R6: stall with interrupt
      cfg_rww = 2'b01;
      txn(1'b1, 2'b10, 24'h800000, 32'h44440004, lat, errc, rd);
      txn(1'b0, 2'b10, 24'h800010, 0, lat, errc, rd);
      chk(rd == 32'h44440004, "R5 stalled data bank read", rd, 32'h44440004);
      chk(irq_stall == 1'b1, "R6 stall irq with policy 01", {31'd0, irq_stall}, 32'h1);

      // R9: sticky, clear isolation
      repeat (5) @(negedge clk);
      chk(irq_stall == 1'b1, "R9 stall flag sticky", {31'd0, irq_stall}, 32'h1);
      flag_clr = 2'b10; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
      chk(irq_stall == 1'b1, "R9 abort-clear leaves stall flag", {31'd0, irq_stall}, 32'h1);
      flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
      chk(irq_stall == 1'b0, "R9 stall flag cleared", {31'd0, irq_stall}, 32'h0);

      // R7/R8: abort without interrupt
      wait_idle();
      cfg_rww = 2'b10;
      txn(1'b1, 2'b10, 24'h000000, 32'h55550005, lat, errc, rd);
      txn(1'b0, 2'b10, 24'h000000, 0, lat, errc, rd);
      chk(lat > 2 && lat <= ABRT + 3, "R7 abort latency", lat, ABRT + 3);
      chk(rd == 32'h33330003, "R7 aborted read returns old word", rd, 32'h33330003);
      chk(irq_abort == 1'b0, "R8 no abort irq with policy 10", {31'd0, irq_abort}, 32'h0);
      chk(bank_busy == 2'b00, "R7 bank idle after abort", {30'd0, bank_busy}, 32'h0);
      txn(1'b0, 2'b10, 24'h000000, 0, lat, errc, rd);
      chk(rd == 32'h33330003, "R7 aborted word discarded", rd, 32'h33330003);

      // R7/R8: abort with interrupt
      cfg_rww = 2'b11;
      txn(1'b1, 2'b10, 24'h800000, 32'h66660006, lat, errc, rd);
      txn(1'b0, 2'b10, 24'h800000, 0, lat, errc, rd);
      chk(rd == 32'h44440004, "R7 data bank abort keeps old word", rd, 32'h44440004);
      chk(irq_abort == 1'b1 && irq_stall == 1'b0, "R8 abort irq with policy 11",
          {30'd0, irq_abort, irq_stall}, 32'h2);
      txn(1'b0, 2'b10, 24'h800000, 0, lat, errc, rd);
      chk(irq_abort == 1'b1, "R9 abort flag sticky", {31'd0, irq_abort}, 32'h1);
      flag_clr = 2'b10; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
      chk(irq_abort == 1'b0, "R9 abort flag cleared", {31'd0, irq_abort}, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule